// File: doc/BRIEF.md
# Video DRAM Cycle Mode Decoder

This block runs in a fast system clock domain and watches the five active-low control strobes of the random-access port of a dual-port video DRAM. The strobes are the row strobe, the column strobe, the transfer/output-enable strobe, the write-mask/write-enable strobe and the serial-enable strobe. Each strobe is brought into the clock domain through a synchroniser chain. The address and data pins go through a matching delay, so every strobe edge lines up with the pin values that were present when it happened. Only the row, column and write-mask/write-enable strobes are edge-detected.

When the row strobe falls, the block samples the levels of the other four strobes and picks the operation for the whole row cycle. The operation is a plain RAM cycle, a masked RAM cycle, an internal refresh, or one of three kinds of transfer between the array and the serial register. At that same edge it captures either the row address or the refresh row, and the write mask. Column strobe falls capture the column address, or the serial start (tap) address in a transfer cycle. The block then gives the rest of the controller:

- a write strobe vector,
- a data-output enable,
- the direction of the serial port,
- a flag for a transfer that ended without a tap address.

Top module: `vdram_cycle_decoder`

## Requirements
- R1: After reset the outputs read as follows. `cyc_type` is 0 and `cyc_pulse`, `wr_strobe`, `wr_data`, `wmask`, `row_addr`, `refresh_row`, `col_addr` and `col_valid` are all zero. `dout_en`, `ser_input_mode` and `xfer_illegal` are low.
- R2: Every row-strobe fall gives exactly one one-clock `cyc_pulse`, and `cyc_type` holds the decoded cycle until the next fall. The codes are chosen from the strobe levels sampled at that fall, checked in this order:
  - column strobe low: 3 (refresh);
  - otherwise transfer/output-enable high and write-enable high: 1 (RAM);
  - transfer/output-enable high and write-enable low: 2 (masked RAM);
  - transfer/output-enable low and write-enable high: 4 (read transfer);
  - transfer/output-enable low, write-enable low and serial-enable low: 5 (write transfer);
  - transfer/output-enable low, write-enable low and serial-enable high: 6 (pseudo write transfer).
- R3: In a refresh cycle, `row_addr` takes the value of the internal refresh counter `refresh_row`. The counter steps by one when that cycle's row strobe rises, and it wraps from all ones to zero.
- R4: In every cycle other than refresh, `row_addr` captures `addr_in` at the row-strobe fall.
- R5: Each column-strobe fall inside an active cycle other than refresh captures `addr_in[COL_W-1:0]` into `col_addr` and sets `col_valid`. `col_valid` clears at the next row-strobe fall, and it stays low throughout a refresh cycle.
- R6: `wmask` is captured at the row-strobe fall:
  - in a masked RAM cycle it takes `dq_in` (bit 1 allows that bit, bit 0 blocks it);
  - in a plain RAM cycle it is all ones;
  - in refresh and transfer cycles it is zero.
  The mask holds across every page-mode column cycle of that row cycle, and the next row cycle replaces it.
- R7: A write happens in RAM cycles only, at whichever of the column strobe and the write-enable strobe falls later, once both are low. For one clock `wr_strobe` equals `wmask`, and `wr_data` takes `dq_in` as it was at that later fall. Transfer and refresh cycles never raise `wr_strobe`.
- R8: `dout_en` is high in a RAM cycle once a column has been captured, while the column strobe and the transfer/output-enable strobe are both low. It drops when either of them rises first, it stays up after the row strobe rises, and it is never high in transfer or refresh cycles.
- R9: `ser_input_mode` goes to 0 (output) on a read transfer and to 1 (input) on a write or pseudo write transfer. RAM and refresh cycles leave it unchanged.
- R10: When a transfer cycle ends at the row-strobe rise without any column-strobe fall, `xfer_illegal` goes high with `col_valid` low. It clears at the next row-strobe fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| dtoe_n | input | 1 | Transfer select / output enable strobe, active low |
| wbwe_n | input | 1 | Write-mask select / write enable strobe, active low |
| se_n | input | 1 | Serial enable strobe, active low |
| addr_in | input | ROW_W | Multiplexed row/column address pins |
| dq_in | input | DQ_W | Data pins, also the mask source |
| cyc_pulse | output | 1 | One-clock pulse per decoded cycle |
| cyc_type | output | 3 | Decoded cycle code (R2) |
| row_addr | output | ROW_W | Row of the current cycle |
| refresh_row | output | ROW_W | Internal refresh counter |
| col_addr | output | COL_W | Column or tap address |
| col_valid | output | 1 | Column/tap captured in this cycle |
| wmask | output | DQ_W | Write mask of the current cycle |
| wr_strobe | output | DQ_W | Per-bit write pulse |
| wr_data | output | DQ_W | Data of the last write |
| dout_en | output | 1 | Read data drive enable |
| ser_input_mode | output | 1 | Serial port direction, 1 = input |
| xfer_illegal | output | 1 | Transfer ended with no tap address |

## Verification
The bench builds the block with a 4-bit row, a 3-bit column and a 4-bit data path, with two synchroniser stages. The 4-bit row lets seventeen refresh cycles carry the counter through its wrap. The 4-bit data path lets the bench apply all sixteen write masks, each with a late write-enable write and an early page-mode write. All sixteen combinations of the four sampled strobe levels are driven into row-strobe falls. The expected cycle code, row, mask, serial direction and illegal-transfer flag are worked out from those levels.

// File: rtl/vdram_pkg.sv
package vdram_pkg;

   typedef enum logic [2:0] {
      CYC_NONE     = 3'd0,
      CYC_RAM      = 3'd1,
      CYC_RAM_MASK = 3'd2,
      CYC_REFRESH  = 3'd3,
      CYC_XFER_RD  = 3'd4,
      CYC_XFER_WR  = 3'd5,
      CYC_XFER_PS  = 3'd6
   } cyc_e;

   // strobe positions in the synchronised level vector
   localparam int STB_RAS  = 0;
   localparam int STB_CAS  = 1;
   localparam int STB_DTOE = 2;
   localparam int STB_WBWE = 3;
   localparam int STB_SE   = 4;
   localparam int STB_N    = 5;

   function automatic logic is_ram(cyc_e c);
      return (c == CYC_RAM) || (c == CYC_RAM_MASK);
   endfunction

   function automatic logic is_xfer(cyc_e c);
      return (c == CYC_XFER_RD) || (c == CYC_XFER_WR) || (c == CYC_XFER_PS);
   endfunction

endpackage

// File: rtl/vdram_pipe.sv
module vdram_pipe #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/vdram_strobe_front.sv
module vdram_strobe_front
   import vdram_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [STB_N-1:0] strobe_n,
   output logic [STB_N-1:0] lvl,
   output logic             ras_fall,
   output logic             ras_rise,
   output logic             cas_fall,
   output logic             wbwe_fall
);
   localparam logic [STB_N-1:0] IDLE_LVL = '1;

   logic ras_p, cas_p, wbwe_p;

   vdram_pipe #(.W(STB_N), .STAGES(STAGES), .RST_VAL(IDLE_LVL)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (strobe_n),
      .q    (lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_p  <= 1'b1;
         cas_p  <= 1'b1;
         wbwe_p <= 1'b1;
      end else begin
         ras_p  <= lvl[STB_RAS];
         cas_p  <= lvl[STB_CAS];
         wbwe_p <= lvl[STB_WBWE];
      end
   end

   assign ras_fall  = ras_p  & ~lvl[STB_RAS];
   assign ras_rise  = ~ras_p &  lvl[STB_RAS];
   assign cas_fall  = cas_p  & ~lvl[STB_CAS];
   assign wbwe_fall = wbwe_p & ~lvl[STB_WBWE];
endmodule

// File: rtl/vdram_cycle_classify.sv
module vdram_cycle_classify
   import vdram_pkg::*;
#(
   parameter int ROW_W = 9,
   parameter int DQ_W  = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_fall,
   input  logic             ras_rise,
   input  logic             cas_lvl,
   input  logic             dtoe_lvl,
   input  logic             wbwe_lvl,
   input  logic             se_lvl,
   input  logic [ROW_W-1:0] row_in,
   input  logic [DQ_W-1:0]  dq_in,
   output cyc_e             cyc_type,
   output logic             cyc_pulse,
   output logic             ras_active,
   output logic [ROW_W-1:0] row_addr,
   output logic [ROW_W-1:0] refresh_row,
   output logic [DQ_W-1:0]  wmask,
   output logic             ser_input_mode
);
   localparam logic [DQ_W-1:0] ALL_EN = '1;

   cyc_e next_type;

   always_comb begin
      if (!cas_lvl)         next_type = CYC_REFRESH;
      else if (dtoe_lvl)    next_type = wbwe_lvl ? CYC_RAM : CYC_RAM_MASK;
      else if (wbwe_lvl)    next_type = CYC_XFER_RD;
      else                  next_type = se_lvl ? CYC_XFER_PS : CYC_XFER_WR;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_type       <= CYC_NONE;
         cyc_pulse      <= 1'b0;
         ras_active     <= 1'b0;
         row_addr       <= '0;
         refresh_row    <= '0;
         wmask          <= '0;
         ser_input_mode <= 1'b0;
      end else begin
         cyc_pulse <= ras_fall;
         if (ras_fall) begin
            cyc_type   <= next_type;
            ras_active <= 1'b1;
            row_addr   <= (next_type == CYC_REFRESH) ? refresh_row : row_in;
            case (next_type)
               CYC_RAM:      wmask <= ALL_EN;
               CYC_RAM_MASK: wmask <= dq_in;
               default:      wmask <= '0;
            endcase
            if (next_type == CYC_XFER_RD)
               ser_input_mode <= 1'b0;
            else if (next_type == CYC_XFER_WR || next_type == CYC_XFER_PS)
               ser_input_mode <= 1'b1;
         end else if (ras_rise) begin
            ras_active <= 1'b0;
            if (cyc_type == CYC_REFRESH)
               refresh_row <= refresh_row + 1'b1;
         end
      end
   end
endmodule

// File: rtl/vdram_col_write.sv
module vdram_col_write
   import vdram_pkg::*;
#(
   parameter int COL_W    = 8,
   parameter int DQ_W     = 8,
   parameter bit DOUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cyc_e             cyc_type,
   input  logic             ras_active,
   input  logic             ras_lvl,
   input  logic             ras_fall,
   input  logic             ras_rise,
   input  logic             cas_lvl,
   input  logic             cas_fall,
   input  logic             wbwe_lvl,
   input  logic             wbwe_fall,
   input  logic             dtoe_lvl,
   input  logic [COL_W-1:0] col_in,
   input  logic [DQ_W-1:0]  dq_in,
   input  logic [DQ_W-1:0]  wmask,
   output logic [COL_W-1:0] col_addr,
   output logic             col_valid,
   output logic [DQ_W-1:0]  wr_strobe,
   output logic [DQ_W-1:0]  wr_data,
   output logic             dout_en,
   output logic             xfer_illegal
);
   logic ram_cyc, xfer_cyc, in_cycle, col_evt, wr_evt, dout_nx;

   assign ram_cyc  = is_ram(cyc_type);
   assign xfer_cyc = is_xfer(cyc_type);
   assign in_cycle = ras_active & ~ras_lvl;
   assign col_evt  = in_cycle & cas_fall & (ram_cyc | xfer_cyc);
   // later of the two falls: both low now, and one of them just fell
   assign wr_evt   = in_cycle & ram_cyc & (cas_fall | wbwe_fall) & ~cas_lvl & ~wbwe_lvl;
   assign dout_nx  = ram_cyc & col_valid & ~cas_lvl & ~dtoe_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_addr     <= '0;
         col_valid    <= 1'b0;
         wr_strobe    <= '0;
         wr_data      <= '0;
         xfer_illegal <= 1'b0;
      end else begin
         wr_strobe <= wr_evt ? wmask : '0;
         if (wr_evt) wr_data <= dq_in;
         if (ras_fall) begin
            col_valid    <= 1'b0;
            xfer_illegal <= 1'b0;
         end else begin
            if (col_evt) begin
               col_addr  <= col_in;
               col_valid <= 1'b1;
            end
            if (ras_rise && xfer_cyc && !col_valid)
               xfer_illegal <= 1'b1;
         end
      end
   end

   generate
      if (DOUT_REG) begin : g_dout_reg
         logic dout_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dout_q <= 1'b0;
            else        dout_q <= dout_nx;
         end
         assign dout_en = dout_q;
      end else begin : g_dout_comb
         assign dout_en = dout_nx;
      end
   endgenerate
endmodule

// File: rtl/vdram_cycle_decoder.sv
module vdram_cycle_decoder
   import vdram_pkg::*;
#(
   parameter int ROW_W       = 9,
   parameter int COL_W       = 8,
   parameter int DQ_W        = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit DOUT_REG    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             dtoe_n,
   input  logic             wbwe_n,
   input  logic             se_n,
   input  logic [ROW_W-1:0] addr_in,
   input  logic [DQ_W-1:0]  dq_in,
   output logic             cyc_pulse,
   output logic [2:0]       cyc_type,
   output logic [ROW_W-1:0] row_addr,
   output logic [ROW_W-1:0] refresh_row,
   output logic [COL_W-1:0] col_addr,
   output logic             col_valid,
   output logic [DQ_W-1:0]  wmask,
   output logic [DQ_W-1:0]  wr_strobe,
   output logic [DQ_W-1:0]  wr_data,
   output logic             dout_en,
   output logic             ser_input_mode,
   output logic             xfer_illegal
);
   localparam int BUS_W = ROW_W + DQ_W;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (COL_W > ROW_W || COL_W < 1) begin : g_bad_col
         $error("COL_W must lie in 1..ROW_W");
      end
      if (DQ_W < 1 || ROW_W < 1) begin : g_bad_w
         $error("ROW_W and DQ_W must be positive");
      end
   endgenerate

   logic [STB_N-1:0] lvl;
   logic             ras_fall, ras_rise, cas_fall, wbwe_fall, ras_active;
   logic [BUS_W-1:0] bus_q;
   logic [ROW_W-1:0] addr_q;
   logic [DQ_W-1:0]  dq_q;
   cyc_e             type_q;

   vdram_strobe_front #(.STAGES(SYNC_STAGES)) u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_n ({se_n, wbwe_n, dtoe_n, cas_n, ras_n}),
      .lvl      (lvl),
      .ras_fall (ras_fall),
      .ras_rise (ras_rise),
      .cas_fall (cas_fall),
      .wbwe_fall(wbwe_fall)
   );

   // address and data delayed by the same depth as the strobes
   vdram_pipe #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_bus (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({addr_in, dq_in}),
      .q    (bus_q)
   );
   assign addr_q = bus_q[BUS_W-1:DQ_W];
   assign dq_q   = bus_q[DQ_W-1:0];

   vdram_cycle_classify #(.ROW_W(ROW_W), .DQ_W(DQ_W)) u_class (
      .clk           (clk),
      .rst_n         (rst_n),
      .ras_fall      (ras_fall),
      .ras_rise      (ras_rise),
      .cas_lvl       (lvl[STB_CAS]),
      .dtoe_lvl      (lvl[STB_DTOE]),
      .wbwe_lvl      (lvl[STB_WBWE]),
      .se_lvl        (lvl[STB_SE]),
      .row_in        (addr_q),
      .dq_in         (dq_q),
      .cyc_type      (type_q),
      .cyc_pulse     (cyc_pulse),
      .ras_active    (ras_active),
      .row_addr      (row_addr),
      .refresh_row   (refresh_row),
      .wmask         (wmask),
      .ser_input_mode(ser_input_mode)
   );

   vdram_col_write #(.COL_W(COL_W), .DQ_W(DQ_W), .DOUT_REG(DOUT_REG)) u_colw (
      .clk         (clk),
      .rst_n       (rst_n),
      .cyc_type    (type_q),
      .ras_active  (ras_active),
      .ras_lvl     (lvl[STB_RAS]),
      .ras_fall    (ras_fall),
      .ras_rise    (ras_rise),
      .cas_lvl     (lvl[STB_CAS]),
      .cas_fall    (cas_fall),
      .wbwe_lvl    (lvl[STB_WBWE]),
      .wbwe_fall   (wbwe_fall),
      .dtoe_lvl    (lvl[STB_DTOE]),
      .col_in      (addr_q[COL_W-1:0]),
      .dq_in       (dq_q),
      .wmask       (wmask),
      .col_addr    (col_addr),
      .col_valid   (col_valid),
      .wr_strobe   (wr_strobe),
      .wr_data     (wr_data),
      .dout_en     (dout_en),
      .xfer_illegal(xfer_illegal)
   );

   assign cyc_type = type_q;
endmodule

// File: rtl/vdram_cycle_decoder_chk.sv
module vdram_cycle_decoder_chk #(
   parameter int ROW_W = 9,
   parameter int DQ_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cyc_pulse,
   input logic [2:0]       cyc_type,
   input logic [ROW_W-1:0] refresh_row,
   input logic             col_valid,
   input logic [DQ_W-1:0]  wmask,
   input logic [DQ_W-1:0]  wr_strobe,
   input logic             dout_en,
   input logic             ser_input_mode,
   input logic             xfer_illegal
);
   p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_pulse |=> !cyc_pulse);

   p_pulse_coded_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_pulse |-> (cyc_type != 3'd0 && cyc_type != 3'd7));

   p_refresh_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(refresh_row) |-> (cyc_type == 3'd3 && refresh_row == $past(refresh_row) + 1'b1));

   p_strobe_in_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe != '0) |-> ((wr_strobe & ~wmask) == '0 && (cyc_type == 3'd1 || cyc_type == 3'd2)));

   p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe != '0) |=> (wr_strobe == '0));

   p_dout_ram_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> ($past(cyc_type) == 3'd1 || $past(cyc_type) == 3'd2));

   p_mode_on_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ser_input_mode) |-> (cyc_pulse && (cyc_type == 3'd4 || cyc_type == 3'd5 || cyc_type == 3'd6)));

   p_illegal_untapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_illegal |-> !col_valid);
endmodule

bind vdram_cycle_decoder vdram_cycle_decoder_chk #(.ROW_W(ROW_W), .DQ_W(DQ_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cyc_pulse     (cyc_pulse),
   .cyc_type      (cyc_type),
   .refresh_row   (refresh_row),
   .col_valid     (col_valid),
   .wmask         (wmask),
   .wr_strobe     (wr_strobe),
   .dout_en       (dout_en),
   .ser_input_mode(ser_input_mode),
   .xfer_illegal  (xfer_illegal)
);

// File: tb/vdram_cycle_decoder_tb_top.sv
module vdram_cycle_decoder_tb_top;
   localparam int ROW_W = 4;
   localparam int COL_W = 3;
   localparam int DQ_W  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ras_n = 1'b1, cas_n = 1'b1, dtoe_n = 1'b1, wbwe_n = 1'b1, se_n = 1'b1;
   logic [ROW_W-1:0] addr_in = '0;
   logic [DQ_W-1:0]  dq_in = '0;

   logic             cyc_pulse, col_valid, dout_en, ser_input_mode, xfer_illegal;
   logic [2:0]       cyc_type;
   logic [ROW_W-1:0] row_addr, refresh_row;
   logic [COL_W-1:0] col_addr;
   logic [DQ_W-1:0]  wmask, wr_strobe, wr_data;

   int vectors = 0;
   int fails   = 0;
   int pulse_cnt = 0;
   int wr_cnt    = 0;
   int last_strobe = 0;
   int last_data   = 0;

   always #10 clk = ~clk;

   vdram_cycle_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .dtoe_n(dtoe_n),
      .wbwe_n(wbwe_n), .se_n(se_n), .addr_in(addr_in), .dq_in(dq_in),
      .cyc_pulse(cyc_pulse), .cyc_type(cyc_type), .row_addr(row_addr),
      .refresh_row(refresh_row), .col_addr(col_addr), .col_valid(col_valid),
      .wmask(wmask), .wr_strobe(wr_strobe), .wr_data(wr_data), .dout_en(dout_en),
      .ser_input_mode(ser_input_mode), .xfer_illegal(xfer_illegal)
   );

   always @(negedge clk) begin
      if (cyc_pulse) pulse_cnt <= pulse_cnt + 1;
      if (wr_strobe != '0) begin
         wr_cnt      <= wr_cnt + 1;
         last_strobe <= int'(wr_strobe);
         last_data   <= int'(wr_data);
      end
   end

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(string req, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      summary();
      $finish;
   end

   initial begin
      int ref_model = 0;
      int mode_model = 0;
      int pb, wb;
      wait_n(3);
      // R1: reset state
      check("R1 cyc_type", int'(cyc_type), 0);
      check("R1 dout_en", int'(dout_en), 0);
      check("R1 wr_strobe", int'(wr_strobe), 0);
      check("R1 ser_input_mode", int'(ser_input_mode), 0);
      check("R1 refresh_row", int'(refresh_row), 0);
      check("R1 col_valid", int'(col_valid), 0);
      check("R1 xfer_illegal", int'(xfer_illegal), 0);
      check("R1 wmask", int'(wmask), 0);
      check("R1 row_addr", int'(row_addr), 0);
      rst_n = 1'b1;
      wait_n(4);
      check("R1 cyc_pulse", pulse_cnt, 0);

      // Sweep all sampled strobe levels at the row-strobe fall: R2 R3 R4 R5 R6 R9 R10
      wb = wr_cnt;
      for (int i = 0; i < 16; i++) begin
         bit cpre, dt, wbl, sel, do_cas, xf;
         int exp_t, exp_mask;
         cpre = i[3]; dt = i[2]; wbl = i[1]; sel = i[0];
         if (!cpre)    exp_t = 3;
         else if (dt)  exp_t = wbl ? 1 : 2;
         else if (wbl) exp_t = 4;
         else          exp_t = sel ? 6 : 5;
         exp_mask = (exp_t == 1) ? 15 : (exp_t == 2) ? ((~i) & 15) : 0;
         xf = (exp_t >= 4);
         do_cas = (exp_t != 3) && sel;
         cas_n = cpre; dtoe_n = dt; wbwe_n = wbl; se_n = sel;
         addr_in = ROW_W'(i); dq_in = DQ_W'(~i);
         wait_n(6);
         pb = pulse_cnt;
         ras_n = 1'b0;
         wait_n(6);
         check("R2 cyc_type", int'(cyc_type), exp_t);
         check("R2 one pulse", pulse_cnt - pb, 1);
         check((exp_t == 3) ? "R3 refresh row" : "R4 row_addr", int'(row_addr),
               (exp_t == 3) ? ref_model : i);
         check("R6 wmask", int'(wmask), exp_mask);
         if (exp_t == 4) mode_model = 0;
         if (exp_t == 5 || exp_t == 6) mode_model = 1;
         check("R9 ser_input_mode", int'(ser_input_mode), mode_model);
         check("R5 col_valid cleared", int'(col_valid), 0);
         if (exp_t != 3) begin
            dtoe_n = 1'b1; wbwe_n = 1'b1; se_n = 1'b1;
            wait_n(3);
            if (do_cas) begin
               addr_in = ROW_W'(i + 5);
               cas_n = 1'b0;
               wait_n(6);
               check("R5 col_valid", int'(col_valid), 1);
               check("R5 col_addr", int'(col_addr), (i + 5) & 7);
               cas_n = 1'b1;
               wait_n(3);
            end
         end
         ras_n = 1'b1;
         wait_n(6);
         if (exp_t == 3) begin
            ref_model = (ref_model + 1) & 15;
            check("R3 counter step", int'(refresh_row), ref_model);
            cas_n = 1'b1;
            wait_n(3);
         end
         check("R10 xfer_illegal", int'(xfer_illegal), (xf && !do_cas) ? 1 : 0);
         check("R5 col_valid hold", int'(col_valid), do_cas ? 1 : 0);
      end
      check("R7 no write in sweep", wr_cnt - wb, 0);

      // Masked writes for every mask value: R6 R7
      for (int m = 0; m < 16; m++) begin
         dtoe_n = 1'b1; se_n = 1'b1; cas_n = 1'b1; wbwe_n = 1'b0;
         addr_in = ROW_W'(m); dq_in = DQ_W'(m);
         wait_n(6);
         ras_n = 1'b0;
         wait_n(6);
         check("R6 masked wmask", int'(wmask), m);
         check("R2 masked type", int'(cyc_type), 2);
         wbwe_n = 1'b1; dq_in = 4'hF;
         wait_n(3);
         wb = wr_cnt;
         addr_in = 1; cas_n = 1'b0;
         wait_n(3);
         check("R7 no write before enable", wr_cnt - wb, 0);
         dq_in = DQ_W'(m ^ 5); wbwe_n = 1'b0;
         wait_n(6);
         check("R7 late enable count", wr_cnt - wb, (m != 0) ? 1 : 0);
         if (m != 0) begin
            check("R7 late strobe", last_strobe, m);
            check("R7 late data", last_data, m ^ 5);
         end
         wbwe_n = 1'b1; cas_n = 1'b1;
         wait_n(3);
         wb = wr_cnt;
         wbwe_n = 1'b0; dq_in = DQ_W'(m ^ 10);
         wait_n(3);
         addr_in = 2; cas_n = 1'b0;
         wait_n(6);
         check("R6 page mask held count", wr_cnt - wb, (m != 0) ? 1 : 0);
         if (m != 0) begin
            check("R6 page mask held strobe", last_strobe, m);
            check("R7 early data", last_data, m ^ 10);
         end
         cas_n = 1'b1; wbwe_n = 1'b1;
         wait_n(3);
         ras_n = 1'b1;
         wait_n(6);
      end

      // Plain RAM write: mask all ones (R6 R7)
      dq_in = 0; addr_in = 3;
      wait_n(4);
      ras_n = 1'b0;
      wait_n(6);
      check("R6 plain wmask", int'(wmask), 15);
      wb = wr_cnt;
      wbwe_n = 1'b0; dq_in = 9;
      wait_n(3);
      cas_n = 1'b0;
      wait_n(6);
      check("R7 plain count", wr_cnt - wb, 1);
      check("R7 plain strobe", last_strobe, 15);
      check("R7 plain data", last_data, 9);
      cas_n = 1'b1; wbwe_n = 1'b1;
      wait_n(3);
      ras_n = 1'b1;
      wait_n(6);

      // Write transfer with both enables low: no write (R7), input mode (R9)
      dtoe_n = 1'b0; wbwe_n = 1'b0; se_n = 1'b0;
      wait_n(4);
      ras_n = 1'b0;
      wait_n(6);
      wb = wr_cnt;
      cas_n = 1'b0;
      wait_n(6);
      check("R7 no write in transfer", wr_cnt - wb, 0);
      check("R9 write transfer input", int'(ser_input_mode), 1);
      check("R8 no dout in transfer", int'(dout_en), 0);
      cas_n = 1'b1; dtoe_n = 1'b1; wbwe_n = 1'b1; se_n = 1'b1;
      wait_n(3);
      ras_n = 1'b1;
      wait_n(6);

      // Read output enable (R8), then hidden refresh (R3, R8)
      ras_n = 1'b0;
      wait_n(6);
      check("R9 RAM leaves mode", int'(ser_input_mode), 1);
      addr_in = 6; cas_n = 1'b0;
      wait_n(6);
      check("R8 dout off while oe high", int'(dout_en), 0);
      dtoe_n = 1'b0;
      wait_n(6);
      check("R8 dout on", int'(dout_en), 1);
      dtoe_n = 1'b1;
      wait_n(6);
      check("R8 dout off oe rise", int'(dout_en), 0);
      dtoe_n = 1'b0;
      wait_n(6);
      check("R8 dout on again", int'(dout_en), 1);
      cas_n = 1'b1;
      wait_n(6);
      check("R8 dout off cas rise", int'(dout_en), 0);
      cas_n = 1'b0;
      wait_n(6);
      ras_n = 1'b1;
      wait_n(6);
      check("R8 dout holds after row rise", int'(dout_en), 1);
      ras_n = 1'b0;
      wait_n(6);
      check("R3 hidden refresh type", int'(cyc_type), 3);
      check("R3 hidden refresh row", int'(row_addr), ref_model);
      check("R8 dout off in refresh", int'(dout_en), 0);
      ras_n = 1'b1;
      wait_n(6);
      ref_model = (ref_model + 1) & 15;
      dtoe_n = 1'b1; cas_n = 1'b1;
      wait_n(4);

      // Refresh counter wrap: R3
      for (int k = 0; k < 17; k++) begin
         cas_n = 1'b0;
         wait_n(3);
         ras_n = 1'b0;
         wait_n(6);
         check("R3 wrap row", int'(row_addr), ref_model);
         check("R3 wrap type", int'(cyc_type), 3);
         ras_n = 1'b1;
         wait_n(6);
         ref_model = (ref_model + 1) & 15;
         check("R3 wrap counter", int'(refresh_row), ref_model);
         cas_n = 1'b1;
         wait_n(3);
      end

      summary();
      $finish;
   end
endmodule